// File: doc/BRIEF.md
# Word-Register Serial Port with Twin FIFOs

This block is a small asynchronous serial port that sits on a simple 32-bit register bus. Software sees four word registers in a 16-byte window: a receive-data register, a transmit-data register, a status word and a control word. Characters written for transmission queue in a transmit FIFO and leave on `txd` as fixed-format frames; frames arriving on `rxd` are deserialized, checked and queued in a receive FIFO until software reads them. A single interrupt line, gated by a control bit, tells software when there is something to read or when the transmit queue has drained.

The line rate is fixed at build time: one bit lasts `16*CLK_DIV` clock cycles and the receiver samples on a 16x tick. A frame is one low start bit, eight data bits least significant first, an optional parity bit (parameter `PARITY`: 0 none, 1 even, 2 odd) and one high stop bit. Bus reads return data combinationally in the cycle `bus_sel` is high; their side effects (popping a character, clearing error flags) take place at the clock edge that ends that cycle.

The transmitter runs the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. TX_IDLE goes to TX_START when the transmit FIFO holds a character (popping it); TX_START goes to TX_DATA after one bit time; TX_DATA goes to TX_PARITY (parity built) or TX_STOP (no parity) after the eighth bit; TX_PARITY goes to TX_STOP after one bit; TX_STOP returns to TX_IDLE after one bit. The receiver runs RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP. RX_IDLE goes to RX_START on a high-to-low edge of the synchronized line; RX_START goes to RX_DATA if the line is still low at mid-bit, otherwise back to RX_IDLE as a false start; RX_DATA moves on after eight mid-bit samples to RX_PARITY or RX_STOP; RX_PARITY goes to RX_STOP after one sample; RX_STOP samples the stop bit, delivers the character and returns to RX_IDLE.

Top module: `mmio_uart`

## Requirements
- R1: After reset the status word reads 0x04 (only transmit-empty, bit 2, set), the control word reads 0, `txd` is high and `irq` is low.
- R2: Each transmitted frame is a low start bit, the eight data bits least significant first, with `PARITY`=1 a parity bit equal to the XOR of the data bits (its complement with `PARITY`=2), and a high stop bit, each bit lasting `16*CLK_DIV` cycles.
- R3: A well-formed frame on `rxd` is stored in the receive FIFO and sets status bit 0; a read of offset 0x00 returns the oldest character in bits 7:0 and removes it.
- R4: Both FIFOs keep characters in arrival order and hold `FIFO_DEPTH` characters; status bit 1 is set while the receive FIFO is full and bit 3 while the transmit FIFO is full.
- R5: A frame that completes while the receive FIFO is full is discarded and sets the overrun flag, status bit 5.
- R6: A frame whose stop bit is sampled low sets the framing flag, status bit 6; its character is still stored.
- R7: A frame whose parity bit disagrees with the built parity sets the parity flag, status bit 7; its character is still stored.
- R8: A read of the status word (offset 0x08) clears bits 7:5; an error arriving in the same cycle as that read stays set.
- R9: A write to the transmit register (offset 0x04) while the transmit FIFO is full is ignored and never sent.
- R10: A read of the receive register while the receive FIFO is empty returns zero and changes no state.
- R11: A write to control (offset 0x0C) with bit 0 set empties the transmit FIFO and with bit 1 set empties the receive FIFO, both for that cycle only; these bits read back as zero; bit 4 is the interrupt enable, held until rewritten and visible in control bit 4 and status bit 4.
- R12: With interrupts enabled, `irq` pulses for one cycle when the receive FIFO goes from empty to non-empty or the transmit FIFO goes from non-empty to empty; with them disabled `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset in the window; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_sel` is high |
| irq | output | 1 | One-cycle interrupt pulse |
| rxd | input | 1 | Serial input line, idles high |
| txd | output | 1 | Serial output line, idles high |

## Verification
The bench builds the port with `CLK_DIV`=2, so a bit lasts 32 cycles and a whole frame well under 400, which lets it fill and overflow each 16-deep FIFO, drain seventeen queued characters and still finish quickly. It uses `PARITY`=1 (even), which brings the parity bit on the transmit side and the parity-error path on the receive side within reach; the no-parity and odd builds change only which bit is compared and are not exercised. `FIFO_DEPTH` stays at 16 so the full, overrun and ignored-write boundaries fall where the requirements place them.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_t;

    // word index taken from bus_addr[3:2]
    localparam logic [1:0] WIDX_RXD  = 2'd0;
    localparam logic [1:0] WIDX_TXD  = 2'd1;
    localparam logic [1:0] WIDX_STAT = 2'd2;
    localparam logic [1:0] WIDX_CTRL = 2'd3;

    // mode 1: even parity, mode 2: odd parity
    function automatic logic parity_of(input logic [7:0] d, input int mode);
        return (mode == 2) ? ~(^d) : ^d;
    endfunction

endpackage

// File: rtl/mmio_uart_fifo.sv
module mmio_uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign rdata = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full)  wp <= wp + 1'b1;
            if (pop  && !empty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wp[AW-1:0]] <= wdata;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/mmio_uart_tx.sv
module mmio_uart_tx
    import mmio_uart_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int PARITY  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       txd
);
    localparam int BIT_CLKS = 16 * CLK_DIV;
    localparam int CW       = $clog2(BIT_CLKS);

    tx_state_t       state, nxt;
    logic [CW-1:0]   cnt;
    logic [2:0]      bitn;
    logic [7:0]      sh;
    logic            par;
    logic            bit_end;

    assign bit_end  = (cnt == CW'(BIT_CLKS - 1));
    assign fifo_pop = (state == TX_IDLE) && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:   if (!fifo_empty) nxt = TX_START;
            TX_START:  if (bit_end) nxt = TX_DATA;
            TX_DATA:   if (bit_end && bitn == 3'd7) nxt = (PARITY != 0) ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nxt = TX_STOP;
            TX_STOP:   if (bit_end) nxt = TX_IDLE;
            default:   nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            par  <= 1'b0;
        end else begin
            cnt <= (state == TX_IDLE || bit_end) ? '0 : cnt + 1'b1;
            if (fifo_pop) begin
                sh   <= fifo_data;
                par  <= parity_of(fifo_data, PARITY);
                bitn <= '0;
            end else if (state == TX_DATA && bit_end) begin
                sh   <= {1'b0, sh[7:1]};
                bitn <= bitn + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = sh[0];
            TX_PARITY: txd = par;
            default:   txd = 1'b1;
        endcase
    end

    // R2
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && $past(state) != TX_START) |-> $past(fifo_pop));

endmodule

// File: rtl/mmio_uart_rx.sv
module mmio_uart_rx
    import mmio_uart_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int PARITY  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] data,
    output logic       par_err,
    output logic       frm_err
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    rx_state_t      state, nxt;
    logic           rx_m, rx_s, rx_d;
    logic [DW-1:0]  dcnt;
    logic [3:0]     sub;
    logic [2:0]     bitn;
    logic [7:0]     sh;
    logic           pbit, par_ok;
    logic           tick, mid, last;

    assign tick = (dcnt == DW'(CLK_DIV - 1));
    assign mid  = tick && (sub == 4'd7);
    assign last = tick && (sub == 4'd15);

    generate
        if (PARITY == 0) begin : g_nopar
            assign par_ok = 1'b1;
        end else begin : g_par
            assign par_ok = (pbit == parity_of(sh, PARITY));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
            rx_d <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
            rx_d <= rx_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (rx_d && !rx_s) nxt = RX_START;
            RX_START:  if (mid) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (last && bitn == 3'd7) nxt = (PARITY != 0) ? RX_PARITY : RX_STOP;
            RX_PARITY: if (last) nxt = RX_STOP;
            RX_STOP:   if (last) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt    <= '0;
            sub     <= '0;
            bitn    <= '0;
            sh      <= '0;
            pbit    <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == RX_IDLE) begin
                dcnt <= '0;
                sub  <= '0;
                bitn <= '0;
            end else begin
                dcnt <= tick ? '0 : dcnt + 1'b1;
                if (tick) sub <= (state == RX_START && mid) ? 4'd0 : sub + 4'd1;
                if (state == RX_DATA && last) begin
                    sh   <= {rx_s, sh[7:1]};
                    bitn <= bitn + 1'b1;
                end
                if (state == RX_PARITY && last) pbit <= rx_s;
                if (state == RX_STOP && last) begin
                    done    <= 1'b1;
                    data    <= sh;
                    frm_err <= !rx_s;
                    par_err <= !par_ok;
                end
            end
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
    import mmio_uart_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int PARITY     = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        rxd,
    output logic        txd
);
    logic [1:0] widx;
    logic       wr_txd, wr_ctrl, rd_rxd, rd_stat;
    logic       flush_tx, flush_rx;
    logic       ie, ovr_q, frm_q, par_q;
    logic       rx_ne_q, tx_e_q;

    logic       tx_empty, tx_full, tx_pop, tx_push;
    logic [7:0] tx_q;
    logic       rx_empty, rx_full, rx_push, rx_pop;
    logic [7:0] rx_q;
    logic       rx_done, rx_perr, rx_ferr;
    logic [7:0] rx_char;
    logic [7:0] status;
    logic       unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:5], bus_wdata[3:2]};

    assign widx     = bus_addr[3:2];
    assign wr_txd   = bus_sel &&  bus_wr && (widx == WIDX_TXD);
    assign wr_ctrl  = bus_sel &&  bus_wr && (widx == WIDX_CTRL);
    assign rd_rxd   = bus_sel && !bus_wr && (widx == WIDX_RXD);
    assign rd_stat  = bus_sel && !bus_wr && (widx == WIDX_STAT);
    assign flush_tx = wr_ctrl && bus_wdata[0];
    assign flush_rx = wr_ctrl && bus_wdata[1];

    assign tx_push = wr_txd && !tx_full;
    assign rx_push = rx_done && !rx_full;
    assign rx_pop  = rd_rxd && !rx_empty;

    mmio_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk, .rst_n, .flush(flush_tx), .push(tx_push), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_q), .empty(tx_empty), .full(tx_full));

    mmio_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk, .rst_n, .flush(flush_rx), .push(rx_push), .wdata(rx_char),
        .pop(rx_pop), .rdata(rx_q), .empty(rx_empty), .full(rx_full));

    mmio_uart_tx #(.CLK_DIV(CLK_DIV), .PARITY(PARITY)) u_tx (
        .clk, .rst_n, .fifo_empty(tx_empty), .fifo_data(tx_q),
        .fifo_pop(tx_pop), .txd);

    mmio_uart_rx #(.CLK_DIV(CLK_DIV), .PARITY(PARITY)) u_rx (
        .clk, .rst_n, .rxd, .done(rx_done), .data(rx_char),
        .par_err(rx_perr), .frm_err(rx_ferr));

    assign status = {par_q, frm_q, ovr_q, ie, tx_full, tx_empty, rx_full, !rx_empty};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie      <= 1'b0;
            ovr_q   <= 1'b0;
            frm_q   <= 1'b0;
            par_q   <= 1'b0;
            rx_ne_q <= 1'b0;
            tx_e_q  <= 1'b1;
            irq     <= 1'b0;
        end else begin
            if (wr_ctrl) ie <= bus_wdata[4];
            if (rd_stat) begin
                ovr_q <= 1'b0;
                frm_q <= 1'b0;
                par_q <= 1'b0;
            end
            if (rx_done && rx_full)             ovr_q <= 1'b1;
            if (rx_done && !rx_full && rx_ferr) frm_q <= 1'b1;
            if (rx_done && !rx_full && rx_perr) par_q <= 1'b1;
            rx_ne_q <= !rx_empty;
            tx_e_q  <= tx_empty;
            irq     <= ie && ((!rx_empty && !rx_ne_q) || (tx_empty && !tx_e_q));
        end
    end

    always_comb begin
        unique case (widx)
            WIDX_RXD:  bus_rdata = {24'd0, rx_empty ? 8'd0 : rx_q};
            WIDX_TXD:  bus_rdata = 32'd0;
            WIDX_STAT: bus_rdata = {24'd0, status};
            WIDX_CTRL: bus_rdata = {27'd0, ie, 4'd0};
            default:   bus_rdata = 32'd0;
        endcase
    end

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ie));

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !rx_done) |=> (!ovr_q && !frm_q && !par_q));

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full) |=> ovr_q);

endmodule

// File: tb/mmio_uart_tb.sv
`timescale 1ns/1ps
module mmio_uart_tb;
    localparam int CLK_DIV = 2;
    localparam int DEPTH   = 16;
    localparam int PAR     = 1;
    localparam int BIT     = 16 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rxd = 1'b1;
    logic        txd;

    int total = 0;
    int bad   = 0;
    int irq_cnt = 0;
    logic [7:0] cap [32];
    logic       cap_ok [32];

    always #2.5 clk = ~clk;
    always @(posedge clk) if (irq) irq_cnt++;

    mmio_uart #(.CLK_DIV(CLK_DIV), .FIFO_DEPTH(DEPTH), .PARITY(PAR)) u_dut (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .irq, .rxd, .txd);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_bits(input int n);
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        @(negedge clk);
        rxd = 1'b0; wait_bits(1);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; wait_bits(1);
        end
        rxd = (^d) ^ bad_par; wait_bits(1);
        rxd = !bad_stop; wait_bits(1);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic capture(input int idx);
        logic [7:0] d;
        logic s0, p, sp;
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        s0 = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            d[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        p = txd;
        repeat (BIT) @(negedge clk);
        sp = txd;
        cap[idx]    = d;
        cap_ok[idx] = (s0 == 1'b0) && (p == ^d) && (sp == 1'b1);
    endtask

    task automatic check_line_quiet(input string req);
        logic seen_low = 1'b0;
        repeat (3 * BIT) begin
            @(negedge clk);
            if (txd !== 1'b1) seen_low = 1'b1;
        end
        check(req, {31'd0, seen_low}, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 txd idle", {31'd0, txd}, 32'd1);
        check("R1 irq low", {31'd0, irq}, 32'd0);
        bus_read(4'h8, v); check("R1 status", v, 32'h04);
        bus_read(4'hC, v); check("R1 control", v, 32'h00);
    endtask

    task automatic t_tx_frame();
        int base = irq_cnt;
        bus_write(4'h4, 32'hFFFF_FFA5);
        capture(0);
        check("R2 tx data", {24'd0, cap[0]}, 32'hA5);
        check("R2 tx framing/parity", {31'd0, cap_ok[0]}, 32'd1);
        check("R12 no irq when disabled", irq_cnt - base, 32'd0);
    endtask

    task automatic t_rx_basic();
        logic [31:0] v;
        send_frame(8'h3C, 1'b0, 1'b0);
        bus_read(4'h8, v); check("R3 status valid", v, 32'h05);
        bus_read(4'h0, v); check("R3 rx data", v, 32'h3C);
        bus_read(4'h8, v); check("R3 status after pop", v, 32'h04);
        bus_read(4'h0, v); check("R10 empty read zero", v, 32'h00);
        bus_read(4'h8, v); check("R10 status unchanged", v, 32'h04);
    endtask

    task automatic t_rx_errors();
        logic [31:0] v;
        send_frame(8'h55, 1'b0, 1'b1);
        bus_read(4'h8, v); check("R6 framing flag", v, 32'h45);
        bus_read(4'h0, v); check("R6 char kept", v, 32'h55);
        send_frame(8'h81, 1'b1, 1'b0);
        bus_read(4'h8, v); check("R7 parity flag", v, 32'h85);
        bus_read(4'h8, v); check("R8 flags cleared", v, 32'h05);
        bus_read(4'h0, v); check("R7 char kept", v, 32'h81);
    endtask

    task automatic t_rx_full();
        logic [31:0] v;
        for (int i = 0; i < DEPTH; i++) send_frame(8'(i * 7 + 1), 1'b0, 1'b0);
        bus_read(4'h8, v); check("R4 rx full", v, 32'h07);
        send_frame(8'hEE, 1'b0, 1'b0);
        bus_read(4'h8, v); check("R5 overrun flag", v, 32'h27);
        bus_read(4'h8, v); check("R8 overrun cleared", v, 32'h07);
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(4'h0, v); check("R4 rx order", v, 32'(8'(i * 7 + 1)));
        end
        bus_read(4'h0, v); check("R5 dropped char absent", v, 32'h00);
    endtask

    task automatic t_tx_full();
        logic [31:0] v;
        fork
            begin
                for (int i = 0; i < DEPTH + 2; i++) bus_write(4'h4, 32'(8'h10 + i));
                bus_read(4'h8, v); check("R4 tx full", v, 32'h08);
            end
            begin
                for (int i = 0; i < DEPTH + 1; i++) capture(i);
            end
        join
        for (int i = 0; i < DEPTH + 1; i++) begin
            check("R4 tx order", {24'd0, cap[i]}, 32'(8'h10 + i));
            check("R2 tx frame ok", {31'd0, cap_ok[i]}, 32'd1);
        end
        check_line_quiet("R9 write when full ignored");
        bus_read(4'h8, v); check("R9 status after drain", v, 32'h04);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        bus_write(4'hC, 32'h10);
        bus_read(4'hC, v); check("R11 ie readback", v, 32'h10);
        bus_read(4'h8, v); check("R11 ie in status", v, 32'h14);
        bus_write(4'hC, 32'h13);
        bus_read(4'hC, v); check("R11 reset bits read zero", v, 32'h10);
        send_frame(8'h21, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0);
        bus_read(4'h8, v); check("R11 rx has data", v, 32'h15);
        bus_write(4'hC, 32'h12);
        bus_read(4'h8, v); check("R11 rx flushed", v, 32'h14);
        bus_read(4'h0, v); check("R11 rx flushed read", v, 32'h00);
        fork
            begin
                bus_write(4'h4, 32'h31);
                bus_write(4'h4, 32'h32);
                bus_write(4'h4, 32'h33);
                bus_write(4'hC, 32'h11);
                bus_read(4'h8, v); check("R11 tx flushed", v, 32'h14);
            end
            capture(0);
        join
        check("R11 in-flight char sent", {24'd0, cap[0]}, 32'h31);
        check_line_quiet("R11 flushed chars not sent");
        bus_write(4'hC, 32'h00);
        bus_read(4'hC, v); check("R11 ie cleared", v, 32'h00);
    endtask

    task automatic t_irq();
        int base;
        logic [31:0] v;
        bus_write(4'hC, 32'h10);
        base = irq_cnt;
        send_frame(8'h44, 1'b0, 1'b0);
        check("R12 rx irq pulse", irq_cnt - base, 32'd1);
        bus_read(4'h0, v);
        repeat (4) @(negedge clk);
        check("R12 no irq on pop", irq_cnt - base, 32'd1);
        base = irq_cnt;
        bus_write(4'h4, 32'h66);
        capture(0);
        check("R12 tx empty irq pulse", irq_cnt - base, 32'd1);
        bus_write(4'hC, 32'h00);
        base = irq_cnt;
        send_frame(8'h77, 1'b0, 1'b0);
        check("R12 masked irq", irq_cnt - base, 32'd0);
        bus_read(4'h0, v); check("R3 rx while masked", v, 32'h77);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_tx_frame();
        t_rx_basic();
        t_rx_errors();
        t_rx_full();
        t_tx_full();
        t_ctrl();
        t_irq();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule